// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block sits between a synchronous host and one external asynchronous static RAM of 32K locations by 8 bits. The host presents a request (read or write, a 15-bit address and a write byte) and holds it until the controller answers with a one-clock ready pulse. For a read, that pulse returns the byte. The controller produces the memory address, the active-low chip select, output enable and write strobe, and drives the shared data bus through a tristate enable.

All strobe phases are counted in system clocks. The counts come from nanosecond timing parameters and the clock period. Each count is the ceiling of the quotient, and is never less than one clock.

A read holds chip select and output enable low until the slowest of three output delays has passed. These are the address access time, the chip-select-to-output time and the output-enable-to-output time. A write holds chip select and the write strobe low together for the longer of the pulse width and the data setup time. It then ends the write by raising the write strobe while chip select is still low. A recovery interval keeps every cycle at or above the minimum cycle time before the next request is taken.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and afterwards with no request, mem_ce_n, mem_oe_n and mem_we_n are 1, rsp_ready is 0 and the data bus is not driven.
- R2: A read holds mem_ce_n=0 and mem_oe_n=0 with mem_we_n=1 for RD clocks, where RD = ceil(max(T_ACC, T_CO, T_OE) / CLK_NS). The byte on the bus at the end of that window is returned on rsp_rdata together with rsp_ready, which rises RD clocks after the accepting edge.
- R3: A write holds mem_ce_n=0 and mem_we_n=0 with mem_oe_n=1 for WP clocks, where WP = ceil(max(T_WP, T_DS) / CLK_NS). The write byte is driven, unchanged, for the whole of that window. rsp_ready rises WP clocks after the accepting edge.
- R4: A write ends with mem_we_n rising while mem_ce_n stays 0 for one further clock. The data bus is released whenever mem_we_n is 1.
- R5: Address and write data are captured at acceptance. mem_addr does not change while mem_ce_n stays 0, whatever the host does to its request inputs.
- R6: rsp_ready is a single-clock pulse, raised once per cycle at its completion, and only with mem_oe_n and mem_we_n both 1.
- R7: Two successive falls of mem_ce_n are at least ceil(T_RC/CLK_NS) clocks apart after a read and ceil(T_WC/CLK_NS) clocks apart after a write. mem_ce_n is high for at least one clock between cycles. After a write, mem_we_n stays high for at least ceil(T_WR/CLK_NS) clocks before the next cycle starts.
- R8: Every phase count equals the ceiling of its nanosecond value over CLK_NS, with a minimum of one clock.
- R9: A request is accepted only when the controller is idle. Changing req_valid, req_write, req_addr or req_wdata during a cycle starts no extra cycle and alters nothing on the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte read, valid with rsp_ready |
| mem_addr | output | 15 | Address to the memory |
| mem_dq | inout | 8 | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The embedded properties check the following on every clock:
- The write strobe only falls inside chip select and never overlaps output enable.
- The bus is driven only while the write strobe is low.
- The write strobe rises before chip select.
- The address is frozen during chip select.
- The ready pulse lasts one clock.
- Chip select falls only out of idle.

The strobe lengths against the nanosecond table, the correctness of sampled read data, and the spacing between back-to-back cycles only show up in the bench's scenarios. There, a timed memory model returns corrupted data until the access time has elapsed, and it measures pulse widths and cycle spacing.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WEND,
        ST_RECOV
    } sramc_state_e;

    // ceiling of ns / period, never below one clock
    function automatic int unsigned ns_to_clks(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/1ps
module sramc_phase_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o); // R8

endmodule

// File: rtl/sramc_dq_pad.sv
`timescale 1ns/1ps
module sramc_dq_pad #(
    parameter int unsigned W = 8
) (
    input  logic         drive_i,
    input  logic [W-1:0] dout_i,
    output logic [W-1:0] din_o,
    inout  wire  [W-1:0] pad_io
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pad_io[b] = drive_i ? dout_i[b] : 1'bz;
    end

    assign din_o = pad_io;

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_NS   = 5,
    parameter int unsigned T_ACC_NS = 70,
    parameter int unsigned T_CO_NS  = 70,
    parameter int unsigned T_OE_NS  = 35,
    parameter int unsigned T_RC_NS  = 70,
    parameter int unsigned T_WP_NS  = 55,
    parameter int unsigned T_DS_NS  = 30,
    parameter int unsigned T_WC_NS  = 70,
    parameter int unsigned T_WR_NS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    // phase lengths in clocks
    localparam int unsigned RD_CLKS = ns_to_clks(max_u(T_ACC_NS, max_u(T_CO_NS, T_OE_NS)), CLK_NS);
    localparam int unsigned WP_CLKS = ns_to_clks(max_u(T_WP_NS, T_DS_NS), CLK_NS);
    localparam int unsigned RC_CLKS = ns_to_clks(T_RC_NS, CLK_NS);
    localparam int unsigned WC_CLKS = ns_to_clks(T_WC_NS, CLK_NS);
    localparam int unsigned WR_CLKS = ns_to_clks(T_WR_NS, CLK_NS);
    // gap after a read: fill the cycle time, at least one deselected clock
    localparam int unsigned RD_GAP  = (RC_CLKS > RD_CLKS + 1) ? RC_CLKS - RD_CLKS : 1;
    // gap after a write: one strobe-high clock already spent with select low
    localparam int unsigned WR_FILL = (WC_CLKS > WP_CLKS + 1) ? WC_CLKS - WP_CLKS - 1 : 0;
    localparam int unsigned WR_RCV  = (WR_CLKS > 1) ? WR_CLKS - 1 : 0;
    localparam int unsigned WR_GAP  = max_u(1, max_u(WR_FILL, WR_RCV));
    localparam int unsigned MAX_PH  = max_u(max_u(RD_CLKS, WP_CLKS), max_u(RD_GAP, WR_GAP));
    localparam int unsigned CNT_W   = $clog2(MAX_PH + 1) + 1;

    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CLKS - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CLKS - 1);
    localparam logic [CNT_W-1:0] RDG_LD = CNT_W'(RD_GAP - 1);
    localparam logic [CNT_W-1:0] WRG_LD = CNT_W'(WR_GAP - 1);

    typedef struct packed {
        sramc_state_e      st;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drive;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rdy;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic [DATA_W-1:0] dq_in;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    sramc_dq_pad #(.W(DATA_W)) u_pad (
        .drive_i (ctl_q.drive),
        .dout_i  (ctl_q.wdata),
        .din_o   (dq_in),
        .pad_io  (mem_dq)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdy = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_write) begin
                        ctl_d.st    = ST_WRITE;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.drive = 1'b1;
                        ctl_d.wdata = req_wdata;
                        tmr_val     = WP_LD;
                    end else begin
                        ctl_d.st   = ST_READ;
                        ctl_d.oe_n = 1'b0;
                        tmr_val    = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    ctl_d.rdata = dq_in;
                    ctl_d.rdy   = 1'b1;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.st    = ST_RECOV;
                    tmr_load    = 1'b1;
                    tmr_val     = RDG_LD;
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    ctl_d.we_n  = 1'b1;
                    ctl_d.drive = 1'b0;
                    ctl_d.rdy   = 1'b1;
                    ctl_d.st    = ST_WEND;
                end
            end
            ST_WEND: begin
                ctl_d.ce_n = 1'b1;
                ctl_d.st   = ST_RECOV;
                tmr_load   = 1'b1;
                tmr_val    = WRG_LD;
            end
            ST_RECOV: begin
                if (tmr_done) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.drive <= 1'b0;
            ctl_q.addr  <= '0;
            ctl_q.wdata <= '0;
            ctl_q.rdata <= '0;
            ctl_q.rdy   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_ready = ctl_q.rdy;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_addr  = ctl_q.addr;
    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R3
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R3
    AST_BUS_ONLY_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n |-> !ctl_q.drive); // R4
    AST_WE_RISE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n); // R4
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R5
    AST_READY_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R6
    AST_READY_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (mem_oe_n && mem_we_n)); // R6
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && req_valid) |=> !mem_ce_n); // R9
    AST_CE_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> ($past(ctl_q.st) == ST_IDLE)); // R9

endmodule

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;

    // expected phase counts, from the timing figures and a 5 ns clock
    function automatic int cdiv(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int RD_NEED  = cdiv(70);   // max(70,70,35)
    localparam int WP_NEED  = cdiv(55);   // max(55,30)
    localparam int CYC_NEED = cdiv(70);
    localparam int WR_NEED  = cdiv(5);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_ready;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    wire  [7:0]  mem_dq;
    logic        mem_ce_n, mem_oe_n, mem_we_n;

    always #2.5 clk = ~clk;

    sram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // ---------------- timed memory model ----------------
    logic [7:0]  mem [logic [14:0]];
    logic        mdl_drv;
    logic [7:0]  mdl_val = 8'h00;
    int          negc = 0;
    int          age = 0;
    bit          rd_prev = 0, wr_prev = 0, ce_prev = 1;
    logic [14:0] addr_prev = '0, wr_addr = '0;
    logic [7:0]  wr_first = '0;
    int          we_low = 0;
    int          last_fall = -1000;
    int          we_rise_at = -1000;
    int          ce_falls = 0;
    bit          last_was_wr = 0;

    assign mdl_drv = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq  = mdl_drv ? mdl_val : 8'hzz;

    always @(negedge clk) begin
        bit rd_now, wr_now;
        logic [7:0] stored;
        negc++;
        if (rst_n) begin
            rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
            wr_now = !mem_ce_n && !mem_we_n;
            if (!mem_ce_n && !ce_prev)
                if (mem_addr != addr_prev) chk(0, "R5 addr moved in cycle", mem_addr, addr_prev);
            if (!mem_ce_n && ce_prev) begin
                ce_falls++;
                chk((negc - last_fall) >= CYC_NEED, "R7 cycle spacing", negc - last_fall, CYC_NEED);
                if (last_was_wr)
                    chk((negc - we_rise_at) >= WR_NEED + 1, "R7 write recovery", negc - we_rise_at, WR_NEED + 1);
                last_fall = negc;
                last_was_wr = 0;
            end
            if (rd_now && rd_prev && mem_addr == addr_prev) age++;
            else if (rd_now) age = 1;
            else age = 0;
            if (wr_now) begin
                if (!mem_oe_n) chk(0, "R3 output enable low in write", 0, 1);
                if (!wr_prev) begin
                    we_low = 1; wr_first = mem_dq; wr_addr = mem_addr;
                end else begin
                    we_low++;
                    if (mem_dq !== wr_first) chk(0, "R3 write data moved", mem_dq, wr_first);
                end
            end
            if (!wr_now && wr_prev) begin
                chk(we_low >= WP_NEED, "R3 write pulse width", we_low, WP_NEED);
                chk(!mem_ce_n, "R4 select held at strobe rise", mem_ce_n, 0);
                mem[wr_addr] = wr_first;
                we_rise_at = negc;
                last_was_wr = 1;
            end
            stored = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
            mdl_val = (age >= RD_NEED) ? stored : ~stored;
            rd_prev = rd_now; wr_prev = wr_now;
        end
        ce_prev = mem_ce_n;
        addr_prev = mem_addr;
    end

    // ---------------- host task ----------------
    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_ready && lat < 200);
        rd = rsp_rdata;
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {write, addr, wdata, expected read}
    localparam logic [31:0] VEC [0:7] = '{
        {1'b1, 15'h0000, 8'h11, 8'h00},
        {1'b1, 15'h7FFF, 8'hEE, 8'h00},
        {1'b1, 15'h1234, 8'h5A, 8'h00},
        {1'b0, 15'h0000, 8'h00, 8'h11},
        {1'b0, 15'h7FFF, 8'h00, 8'hEE},
        {1'b0, 15'h1234, 8'h00, 8'h5A},
        {1'b1, 15'h1234, 8'hC3, 8'h00},
        {1'b0, 15'h1234, 8'h00, 8'hC3}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int lat, falls0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n == 1, "R1 ce_n in reset", mem_ce_n, 1);
        chk(mem_oe_n == 1, "R1 oe_n in reset", mem_oe_n, 1);
        chk(mem_we_n == 1, "R1 we_n in reset", mem_we_n, 1);
        chk(rsp_ready == 0, "R1 ready in reset", rsp_ready, 0);
        rst_n = 1;
        idle(5);
        chk(mem_ce_n == 1 && ce_falls == 0, "R1 quiet without request", ce_falls, 0);

        // table walk: R2 R3 R8 latencies and data
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = VEC[i];
            idle(6);
            do_op(v[31], v[30:16], v[15:8], rd, lat);
            if (v[31]) chk(lat == WP_NEED + 1, "R3 R8 write latency", lat, WP_NEED + 1);
            else begin
                chk(lat == RD_NEED + 1, "R2 R8 read latency", lat, RD_NEED + 1);
                chk(rd == v[7:0], "R2 read data", rd, v[7:0]);
            end
            @(negedge clk);
            chk(rsp_ready == 0, "R6 ready single clock", rsp_ready, 0);
        end

        // R5 R9: host changes its inputs mid-write
        idle(6);
        falls0 = ce_falls;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 15'h0100; req_wdata = 8'h77;
        idle(3);
        req_write = 0; req_addr = 15'h0200; req_wdata = 8'h99;
        idle(2);
        chk(mem_addr == 15'h0100, "R5 address held", mem_addr, 15'h0100);
        lat = 0;
        while (!rsp_ready && lat < 200) begin @(negedge clk); lat++; end
        req_valid = 0;
        idle(8);
        chk(ce_falls - falls0 == 1, "R9 one cycle only", ce_falls - falls0, 1);
        do_op(0, 15'h0100, 8'h00, rd, lat);
        chk(rd == 8'h77, "R5 original data stored", rd, 8'h77);

        // R7: back-to-back write then read, recovery must delay the read
        idle(6);
        do_op(1, 15'h0300, 8'h3C, rd, lat);
        do_op(0, 15'h0300, 8'h00, rd, lat);
        chk(lat > RD_NEED + 1, "R7 read waited for recovery", lat, RD_NEED + 2);
        chk(rd == 8'h3C, "R7 back-to-back data", rd, 8'h3C);
        // R7: read then read
        do_op(0, 15'h7FFF, 8'h00, rd, lat);
        chk(rd == 8'hEE, "R7 read after read", rd, 8'hEE);
        idle(20);
        finish_run();
    end

endmodule